// File: doc/BRIEF.md
# Universal Shift Register with Mode Control

A parallel register of parameterised width (four bits unless set otherwise) that performs one of four operations on each rising clock edge, chosen by a two-bit mode input. It can capture a full parallel word, shift its contents toward the most significant end, shift them toward the least significant end, or keep its value. Each shift direction has its own serial input, so a left shift and a right shift can fill the vacated end with independent data.

An active-high clear forces the register to all zeros at once, without waiting for a clock edge, and overrides every mode for as long as it is held. The current register value is always visible on the parallel output. The width must be at least two.

Top module: `ushift_reg`

## Requirements
- R1: While `clr` is 1 the output `q` is all zeros, and a rise of `clr` in the middle of a clock period clears `q` before the next rising clock edge.
- R2: A rising clock edge that arrives while `clr` is 1 leaves `q` at zero whatever the mode, parallel data or serial inputs.
- R3: With `mode` = 2'b00 a rising edge copies `par_in` into `q`, bit `W-1` of `par_in` landing in the most significant (leftmost) bit.
- R4: With `mode` = 2'b01 a rising edge moves every bit one place toward the MSB, drops the old MSB, and puts `ser_left` into bit 0.
- R5: With `mode` = 2'b10 a rising edge moves every bit one place toward the LSB, drops the old bit 0, and puts `ser_right` into bit `W-1`.
- R6: With `mode` = 2'b11 a rising edge leaves `q` unchanged.
- R7: A serial input has no effect on `q` except in the shift mode of its own direction (`ser_left` only in 2'b01, `ser_right` only in 2'b10).
- R8: `par_in` has no effect on `q` in any mode other than 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all moded operations |
| clr | input | 1 | Asynchronous active-high clear to all zeros |
| mode | input | 2 | 00 load, 01 shift toward MSB, 10 shift toward LSB, 11 hold |
| par_in | input | W | Parallel word captured in load mode |
| ser_left | input | 1 | Bit entering at bit 0 on a shift toward the MSB |
| ser_right | input | 1 | Bit entering at bit W-1 on a shift toward the LSB |
| q | output | W | Current register contents |

## Verification
The clear and a clocked load can coincide: the bench loads all ones, raises `clr` a few nanoseconds into the following period with `mode` still set to load and `par_in` still all ones, and keeps it high across the next rising edge. It judges the output twice, once before that edge to show the drop happens without a clock, and once after the edge to show the pending load lost to the clear. Releasing `clr` afterwards in hold mode confirms the zero value persists and that ordinary loading then resumes.

// File: rtl/ushift_reg.sv
module ushift_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [1:0]   mode,
  input  logic [W-1:0] par_in,
  input  logic         ser_left,
  input  logic         ser_right,
  output logic [W-1:0] q
);

  localparam logic [1:0] M_LOAD  = 2'b00;
  localparam logic [1:0] M_LEFT  = 2'b01;
  localparam logic [1:0] M_RIGHT = 2'b10;

  logic [W-1:0] state;
  logic [W-1:0] nxt;

  always_comb begin
    case (mode)
      M_LOAD:  nxt = par_in;
      M_LEFT:  nxt = {state[W-2:0], ser_left};
      M_RIGHT: nxt = {ser_right, state[W-1:1]};
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) state <= '0;
    else     state <= nxt;
  end

  assign q = state;

endmodule

module ushift_reg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr,
  input logic [1:0]   mode,
  input logic [W-1:0] par_in,
  input logic         ser_left,
  input logic         ser_right,
  input logic [W-1:0] q
);

  always @(posedge clk) begin
    if (clr) assert_clear_zero_R2: assert (q == '0);
  end

  always @(negedge clk) begin
    if (clr) assert_clear_level_R1: assert (q == '0);
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b00) |=> (q == $past(par_in)));

  assert_left_R4: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b01) |=> (q == {$past(q[W-2:0]), $past(ser_left)}));

  assert_right_R5: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b10) |=> (q == {$past(ser_right), $past(q[W-1:1])}));

  assert_hold_R6: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b11) |=> $stable(q));

endmodule

bind ushift_reg ushift_reg_chk #(.W(W)) u_chk (.*);

// File: tb/ushift_reg_bench.sv
module ushift_reg_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic [1:0]   mode = 2'b11;
  logic [W-1:0] par_in = '0;
  logic         ser_left = 1'b0;
  logic         ser_right = 1'b0;
  logic [W-1:0] q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ushift_reg #(.W(W)) u_ushift_reg (
    .clk(clk), .clr(clr), .mode(mode), .par_in(par_in),
    .ser_left(ser_left), .ser_right(ser_right), .q(q)
  );

  task automatic check(input string tag, input logic [W-1:0] exp);
    checks++;
    if (q !== exp) begin
      failures++;
      $display("FAIL %s: q=%b expected=%b", tag, q, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] p,
                      input logic sl, input logic sr,
                      input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    mode = m; par_in = p; ser_left = sl; ser_right = sr;
    @(posedge clk);
    #2;
    check(tag, exp);
  endtask

  task automatic t_reset;
    #5;
    check("R1 reset level", 4'b0000);
    @(negedge clk);
    clr = 1'b0;
    #1;
    check("R1 after release", 4'b0000);
  endtask

  task automatic t_load;
    step(2'b00, 4'b0110, 1'b0, 1'b1, 4'b0110, "R3 load 0110");
  endtask

  task automatic t_shift_right;
    step(2'b10, 4'b1111, 1'b0, 1'b1, 4'b1011, "R5 right sr=1 #1");
    step(2'b10, 4'b0000, 1'b0, 1'b1, 4'b1101, "R5 right sr=1 #2");
  endtask

  task automatic t_shift_left;
    step(2'b01, 4'b0000, 1'b0, 1'b1, 4'b1010, "R4 left sl=0 (R7 sr ignored)");
    step(2'b01, 4'b1111, 1'b1, 1'b0, 4'b0101, "R4 left sl=1");
  endtask

  task automatic t_hold;
    step(2'b11, 4'b1111, 1'b1, 1'b1, 4'b0101, "R6 hold (R8 par_in ignored)");
    step(2'b11, 4'b0000, 1'b0, 1'b0, 4'b0101, "R6 hold second edge");
  endtask

  task automatic t_ignore;
    step(2'b10, 4'b1111, 1'b1, 1'b0, 4'b0010, "R7 right ignores ser_left");
    step(2'b00, 4'b1001, 1'b1, 1'b1, 4'b1001, "R7 load ignores serial");
    step(2'b01, 4'b0110, 1'b0, 1'b0, 4'b0010, "R8 left ignores par_in");
  endtask

  task automatic t_clear_mid;
    step(2'b00, 4'b1111, 1'b0, 1'b0, 4'b1111, "R3 load 1111");
    #3;
    clr = 1'b1;
    #1;
    check("R1 mid-cycle clear", 4'b0000);
    @(posedge clk);
    #2;
    check("R2 clear beats load", 4'b0000);
    @(negedge clk);
    mode = 2'b11;
    clr = 1'b0;
    @(posedge clk);
    #2;
    check("R1 zero kept after release", 4'b0000);
    step(2'b00, 4'b1100, 1'b0, 1'b0, 4'b1100, "R3 load after clear");
  endtask

  initial begin
    t_reset();
    t_load();
    t_shift_right();
    t_shift_left();
    t_hold();
    t_ignore();
    t_clear_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: q=%b expected=completion", q);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule